// File: doc/BRIEF.md
# Tiled Fixed-Point Matrix Multiply Array

This block computes the product C = A × B of two signed fixed-point matrices held in banked on-chip memories outside the block. A grid of D × W multiply-accumulate lanes works on one output tile of D rows and W columns at a time. On every step the controller selects one inner-dimension index p. Each of the D values of A read on that step goes to all W lanes of its grid row. Each of the W values of B goes to all D lanes of its grid column.

Matrix A and matrix C are spread across D banks by row, with row i in bank i mod D. This lets D rows be read, or written, in the same cycle. Matrix B is spread across W banks by column. A single address is shared by all banks of one matrix. After a start pulse the block visits the tiles in row-tile-major order. For each tile it runs p from 0 to N−1, then writes the whole tile to C in one cycle. When the last tile has been written it pulses done. Both tile sizes must divide the matrix sizes: D divides M and W divides K.

Top module: `mm_tile_array`

## Requirements
- R1: Each C element equals the sum over p of fx(A[i][p], B[p][j]). Here fx takes the full 64-bit signed product, shifts it right arithmetically by 22 fractional bits, and keeps the low 32 bits. The data format is 32 bits with 10 integer bits, so 1.0 is 0x0040_0000.
- R2: A bank d, word it·N + p, holds A[it·D + d][p]. The bank data is on a_rdata bits [32d+31:32d]. It is returned one cycle after a_addr is presented.
- R3: B bank w, word p·(K/W) + jt, holds B[p][jt·W + w]. The bank data is on b_rdata bits [32w+31:32w]. It is returned one cycle after b_addr is presented.
- R4: Each tile is written once, with c_we high for a single cycle. c_addr is it·(K/W) + jt, and the tiles are written in increasing c_addr order. Lane d·W + w of c_wdata carries C[it·D + d][jt·W + w]. c_we is never high in two consecutive cycles.
- R5: Every accumulator restarts from zero for each tile. A run gives the same result whatever ran before it.
- R6: done is high for exactly one cycle. It is high in the cycle after the last tile write, which is T·N + 3 rising edges after start is driven, counting the edge that samples start. T is (M/D)·(K/W).
- R7: A start pulse received while a run is in progress is ignored. The run's timing, its results and its single done pulse are unchanged.
- R8: After reset, done and c_we are low.
- R9: Negative products are rounded toward minus infinity. For example, raw −3 times 0.5 contributes −2.
- R10: Accumulation wraps modulo 2^32 on overflow, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when the block is idle |
| done | output | 1 | One-cycle pulse when the run ends |
| a_addr | output | AAW | Word address shared by all A banks |
| a_rdata | input | 32·D | Read data from the D banks of A |
| b_addr | output | BAW | Word address shared by all B banks |
| b_rdata | input | 32·W | Read data from the W banks of B |
| c_we | output | 1 | Write strobe for all C banks |
| c_addr | output | CAW | Tile address for the C write |
| c_wdata | output | 32·D·W | D·W accumulated results |

## Verification
The bench walks a one-hot 1.0 through every position of A, and then through every position of B. A swapped bank index or a wrong address stride would put the product in the wrong C element. Runs are issued back to back, so an accumulator that fails to clear at a tile boundary would carry the previous tile's or the previous run's sum. Dedicated runs cover the corner cases:
- A negative fractional product checks that a design rounding toward zero gives −1 instead of −2 per term.
- An overflowing product checks that a saturating design would disagree.
- A second start during a run checks that a design restarting on it would show a longer run or a second done pulse.

// File: rtl/mm_tile_pkg.sv
package mm_tile_pkg;
    localparam int DATA_W = 32;
    localparam int FRAC_W = 22;

    typedef logic signed [DATA_W-1:0] fx_t;

    // control word travelling alongside the read data
    typedef struct packed {
        logic valid;
        logic first;
        logic last;
        logic final_tile;
    } step_ctl_t;

    function automatic fx_t fx_mul(input fx_t a, input fx_t b);
        logic signed [2*DATA_W-1:0] full;
        full = a * b;
        return full[FRAC_W+DATA_W-1:FRAC_W];
    endfunction

    function automatic int width_of(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/mm_tile_sequencer.sv
module mm_tile_sequencer
    import mm_tile_pkg::*;
#(
    parameter int N  = 3,
    parameter int KT = 2,
    parameter int MT = 2,
    parameter int AAW = 3,
    parameter int BAW = 3,
    parameter int CAW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           finish,
    output step_ctl_t      step,
    output logic [AAW-1:0] a_addr,
    output logic [BAW-1:0] b_addr,
    output logic [CAW-1:0] tile_addr
);
    localparam int PW = width_of(N);
    localparam int JW = width_of(KT);
    localparam int IW = width_of(MT);

    logic          busy, issuing;
    logic [PW-1:0] p;
    logic [JW-1:0] jt;
    logic [IW-1:0] it;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            issuing <= 1'b0;
            p       <= '0;
            jt      <= '0;
            it      <= '0;
        end else begin
            if (!busy && start) begin
                busy    <= 1'b1;
                issuing <= 1'b1;
                p       <= '0;
                jt      <= '0;
                it      <= '0;
            end else if (issuing) begin
                if (p == PW'(N-1)) begin
                    p <= '0;
                    if (jt == JW'(KT-1)) begin
                        jt <= '0;
                        if (it == IW'(MT-1)) begin
                            it      <= '0;
                            issuing <= 1'b0;
                        end else begin
                            it <= it + 1'b1;
                        end
                    end else begin
                        jt <= jt + 1'b1;
                    end
                end else begin
                    p <= p + 1'b1;
                end
            end
            if (finish) busy <= 1'b0;
        end
    end

    always_comb begin
        step.valid      = issuing;
        step.first      = (p == '0);
        step.last       = (p == PW'(N-1));
        step.final_tile = (jt == JW'(KT-1)) && (it == IW'(MT-1));
        a_addr    = AAW'(int'(it) * N + int'(p));
        b_addr    = BAW'(int'(p) * KT + int'(jt));
        tile_addr = CAW'(int'(it) * KT + int'(jt));
    end
endmodule

// File: rtl/mm_mac_lane.sv
module mm_mac_lane
    import mm_tile_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic restart,
    input  fx_t  a_in,
    input  fx_t  b_in,
    output fx_t  acc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (en) begin
            acc <= (restart ? fx_t'(0) : acc) + fx_mul(a_in, b_in);
        end
    end
endmodule

// File: rtl/mm_tile_array.sv
module mm_tile_array
    import mm_tile_pkg::*;
#(
    parameter int M = 4,
    parameter int N = 3,
    parameter int K = 4,
    parameter int D = 2,
    parameter int W = 2,
    localparam int MT  = M / D,
    localparam int KT  = K / W,
    localparam int AAW = width_of(MT * N),
    localparam int BAW = width_of(N * KT),
    localparam int CAW = width_of(MT * KT)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    output logic                    done,
    output logic [AAW-1:0]          a_addr,
    input  logic [D*DATA_W-1:0]     a_rdata,
    output logic [BAW-1:0]          b_addr,
    input  logic [W*DATA_W-1:0]     b_rdata,
    output logic                    c_we,
    output logic [CAW-1:0]          c_addr,
    output logic [D*W*DATA_W-1:0]   c_wdata
);
    step_ctl_t      step, step_q;
    logic [CAW-1:0] tile_addr, tile_addr_q;
    logic           wr_q, wr_final_q, done_q;
    logic [CAW-1:0] wr_addr_q;
    logic           finish;

    assign finish = wr_q && wr_final_q;

    mm_tile_sequencer #(
        .N(N), .KT(KT), .MT(MT), .AAW(AAW), .BAW(BAW), .CAW(CAW)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start), .finish(finish),
        .step(step), .a_addr(a_addr), .b_addr(b_addr), .tile_addr(tile_addr)
    );

    // control delayed by the one-cycle memory read latency
    always_ff @(posedge clk) begin
        if (rst) begin
            step_q      <= '0;
            tile_addr_q <= '0;
            wr_q        <= 1'b0;
            wr_final_q  <= 1'b0;
            wr_addr_q   <= '0;
            done_q      <= 1'b0;
        end else begin
            step_q      <= step;
            tile_addr_q <= tile_addr;
            wr_q        <= step_q.valid && step_q.last;
            wr_final_q  <= step_q.valid && step_q.last && step_q.final_tile;
            wr_addr_q   <= tile_addr_q;
            done_q      <= finish;
        end
    end

    genvar gd, gw;
    generate
        for (gd = 0; gd < D; gd++) begin : g_row
            for (gw = 0; gw < W; gw++) begin : g_col
                fx_t acc;
                mm_mac_lane u_lane (
                    .clk(clk), .rst(rst),
                    .en(step_q.valid), .restart(step_q.first),
                    .a_in(a_rdata[gd*DATA_W +: DATA_W]),
                    .b_in(b_rdata[gw*DATA_W +: DATA_W]),
                    .acc(acc)
                );
                assign c_wdata[(gd*W+gw)*DATA_W +: DATA_W] = acc;
            end
        end
    endgenerate

    assign c_we   = wr_q;
    assign c_addr = wr_addr_q;
    assign done   = done_q;
endmodule

// File: rtl/mm_tile_checker.sv
module mm_tile_checker #(
    parameter int N   = 3,
    parameter int MT  = 2,
    parameter int KT  = 2,
    parameter int AAW = 3,
    parameter int BAW = 3,
    parameter int CAW = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           done,
    input logic           c_we,
    input logic [CAW-1:0] c_addr,
    input logic [AAW-1:0] a_addr,
    input logic [BAW-1:0] b_addr
);
    logic [CAW-1:0] last_addr;
    always_ff @(posedge clk) begin
        if (rst) last_addr <= '0;
        else if (c_we) last_addr <= c_addr;
    end

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    p_done_after_write_r6: assert property (@(posedge clk) disable iff (rst) done |-> $past(c_we));
    p_tile_in_range_r4: assert property (@(posedge clk) disable iff (rst) c_we |-> int'(c_addr) < MT*KT);
    p_tile_order_r4: assert property (@(posedge clk) disable iff (rst)
        (c_we && c_addr != '0) |-> c_addr == last_addr + 1'b1);
    p_a_addr_range_r2: assert property (@(posedge clk) disable iff (rst) int'(a_addr) < MT*N);
    p_b_addr_range_r3: assert property (@(posedge clk) disable iff (rst) int'(b_addr) < N*KT);
    generate
        if (N > 1) begin : g_gap
            p_write_gap_r4: assert property (@(posedge clk) disable iff (rst) c_we |=> !c_we);
        end
    endgenerate
endmodule

bind mm_tile_array mm_tile_checker #(
    .N(N), .MT(MT), .KT(KT), .AAW(AAW), .BAW(BAW), .CAW(CAW)
) u_chk (
    .clk(clk), .rst(rst), .done(done), .c_we(c_we),
    .c_addr(c_addr), .a_addr(a_addr), .b_addr(b_addr)
);

// File: tb/mm_tile_array_test.sv
module mm_tile_array_test;
    localparam int M = 4, N = 3, K = 4, D = 2, W = 2;
    localparam int MT = M / D, KT = K / W, T = MT * KT;
    localparam int AAW = (MT*N > 1) ? $clog2(MT*N) : 1;
    localparam int BAW = (N*KT > 1) ? $clog2(N*KT) : 1;
    localparam int CAW = (T > 1) ? $clog2(T) : 1;
    localparam int ONE = 1 << 22;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic done, c_we;
    logic [AAW-1:0] a_addr;
    logic [BAW-1:0] b_addr;
    logic [CAW-1:0] c_addr;
    logic [D*32-1:0] a_rdata;
    logic [W*32-1:0] b_rdata;
    logic [D*W*32-1:0] c_wdata;

    int checks = 0, errors = 0;
    bit finished = 0;

    int A [M][N];
    int B [N][K];
    int C [M][K];
    int wr_count, order_bad, gap_bad;
    logic prev_we;

    always #5 clk = ~clk;

    mm_tile_array #(.M(M), .N(N), .K(K), .D(D), .W(W)) uut (
        .clk(clk), .rst(rst), .start(start), .done(done),
        .a_addr(a_addr), .a_rdata(a_rdata), .b_addr(b_addr), .b_rdata(b_rdata),
        .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata)
    );

    // bank models, one-cycle read latency (R2, R3)
    always @(posedge clk) begin
        for (int d = 0; d < D; d++)
            a_rdata[d*32 +: 32] <= A[(int'(a_addr)/N)*D + d][int'(a_addr)%N];
        for (int w = 0; w < W; w++)
            b_rdata[w*32 +: 32] <= B[int'(b_addr)/KT][(int'(b_addr)%KT)*W + w];
        if (!rst) begin
            if (c_we) begin
                if (int'(c_addr) != wr_count) order_bad++;
                if (prev_we) gap_bad++;
                for (int d = 0; d < D; d++)
                    for (int w = 0; w < W; w++)
                        C[(int'(c_addr)/KT)*D + d][(int'(c_addr)%KT)*W + w] =
                            c_wdata[(d*W+w)*32 +: 32];
                wr_count++;
            end
            prev_we <= c_we;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int expect_c(input int i, input int j);
        int acc = 0;
        for (int p = 0; p < N; p++) begin
            longint pr = longint'(A[i][p]) * longint'(B[p][j]);
            acc = acc + int'(pr >>> 22);
        end
        return acc;
    endfunction

    task automatic run(input string req, input bit restart_mid);
        int n = 0;
        wr_count = 0; order_bad = 0; gap_bad = 0;
        for (int i = 0; i < M; i++) for (int j = 0; j < K; j++) C[i][j] = 32'hDEAD_BEEF;
        @(negedge clk); start = 1'b1;
        do begin
            @(posedge clk); n++; #1;
            if (n == 1) start = 1'b0;
            if (restart_mid && n == 4) start = 1'b1;
            if (restart_mid && n == 5) start = 1'b0;
        end while (!done && n < 1000);
        check(n == T*N + 3, "R6 done latency", n, T*N + 3);
        @(posedge clk); #1;
        check(!done, "R6 done one cycle", done, 0);
        check(wr_count == T, "R4 write count", wr_count, T);
        check(order_bad == 0, "R4 write order", order_bad, 0);
        check(gap_bad == 0, "R4 write gap", gap_bad, 0);
        for (int i = 0; i < M; i++)
            for (int j = 0; j < K; j++)
                check(C[i][j] == expect_c(i, j), req, C[i][j], expect_c(i, j));
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        prev_we = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(!done, "R8 done after reset", done, 0);
        check(!c_we, "R8 c_we after reset", c_we, 0);
        @(negedge clk); rst = 1'b0;

        // all ones: each element is N * 1.0 (R1)
        for (int i = 0; i < M; i++) for (int p = 0; p < N; p++) A[i][p] = ONE;
        for (int p = 0; p < N; p++) for (int j = 0; j < K; j++) B[p][j] = ONE;
        run("R1 all ones", 0);
        check(C[M-1][K-1] == N*ONE, "R1 sum value", C[M-1][K-1], N*ONE);

        // signed pattern, previous sums must not leak (R1, R5)
        for (int i = 0; i < M; i++) for (int p = 0; p < N; p++) A[i][p] = (((i*3 + p*5) % 7) - 3) * ONE;
        for (int p = 0; p < N; p++) for (int j = 0; j < K; j++) B[p][j] = (((p*2 + j*7) % 5) - 2) * (ONE/4);
        run("R5 fresh accumulation", 0);

        // one-hot sweep over A positions (R2)
        for (int q = 0; q < M*N; q++) begin
            for (int i = 0; i < M; i++) for (int p = 0; p < N; p++) A[i][p] = (i*N + p == q) ? ONE : 0;
            for (int p = 0; p < N; p++) for (int j = 0; j < K; j++) B[p][j] = (p*K + j + 1) * ONE;
            run("R2 A bank layout", 0);
        end

        // one-hot sweep over B positions (R3)
        for (int q = 0; q < N*K; q++) begin
            for (int i = 0; i < M; i++) for (int p = 0; p < N; p++) A[i][p] = (i*N + p + 1) * ONE;
            for (int p = 0; p < N; p++) for (int j = 0; j < K; j++) B[p][j] = (p*K + j == q) ? ONE : 0;
            run("R3 B bank layout", 0);
        end

        // negative fraction rounds down (R9)
        for (int i = 0; i < M; i++) for (int p = 0; p < N; p++) A[i][p] = -3;
        for (int p = 0; p < N; p++) for (int j = 0; j < K; j++) B[p][j] = ONE / 2;
        run("R9 floor rounding", 0);
        check(C[0][0] == -2*N, "R9 floor value", C[0][0], -2*N);

        // overflow wraps (R10)
        for (int i = 0; i < M; i++) for (int p = 0; p < N; p++) A[i][p] = 511 * ONE + i;
        for (int p = 0; p < N; p++) for (int j = 0; j < K; j++) B[p][j] = (p == 1) ? -511 * ONE : 511 * ONE + j;
        run("R10 wrapping sum", 0);

        // start while busy ignored (R7)
        for (int i = 0; i < M; i++) for (int p = 0; p < N; p++) A[i][p] = (i - p) * 12345 + 777;
        for (int p = 0; p < N; p++) for (int j = 0; j < K; j++) B[p][j] = (j + 2*p - 3) * 54321;
        run("R7 start while busy", 1);
        begin
            int extra = 0;
            repeat (2*T*N) begin
                @(posedge clk); #1;
                if (done) extra++;
            end
            check(extra == 0, "R7 no second done", extra, 0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule